// File: doc/BRIEF.md
# Integer Divide and Modulo Unit

This block computes quotients and remainders for a register datapath whose width is the parameter `XLEN` (64 by default). A caller presents two source operands, a four-bit operation code and a one-cycle start pulse. The unit returns a result of register width, an overflow flag and a one-cycle done pulse. The operation code selects signed or unsigned arithmetic, full-width or half-width (word) operands, quotient or remainder, and plain or extended dividend. In the extended forms the dividend is the source shifted up by the operating width.

Arithmetic runs on magnitudes in a restoring divider twice the register width wide, which produces one quotient bit per cycle. Signs are corrected afterwards. Overflow conditions that can be seen from the operands alone finish one cycle after start and skip the iteration. Whenever overflow is reported the result is all zeros. Result bits above a word-form result are driven to a defined value, so every output can be checked exactly.

Top module: `divmod_unit`

## Requirements
- R1: `op_i` bit 0 selects signed, bit 1 selects word form, bit 2 selects remainder, and bit 3 selects extended dividend. Word forms use only `src_a_i[XLEN/2-1:0]` and `src_b_i[XLEN/2-1:0]`, and the upper halves have no effect on the result.
- R2: A signed plain or word operation reports overflow when the divisor is zero. It also reports overflow when the dividend is the most negative value at its width and the divisor is minus one. In both cases it finishes with `done_o` one cycle after start.
- R3: An unsigned plain or word operation reports overflow only for a zero divisor, and then finishes one cycle after start.
- R4: Whenever `ovf_o` is high, `result_o` is all zeros.
- R5: A word quotient, and an unsigned word remainder, appear in the low half of `result_o` with the upper half zero.
- R6: A signed word remainder is sign-extended from bit XLEN/2-1 across all of `result_o`.
- R7: A signed quotient truncates toward zero, and a signed remainder takes the sign of the dividend.
- R8: In extended forms the dividend is the selected source followed by a zero field of equal width. Signed extended forms sign-extend the divisor and unsigned extended forms zero-extend it. The result is always the quotient, so bit 2 is ignored.
- R9: A signed extended divide whose quotient does not fit its destination width as a signed value reports overflow after the full iteration time.
- R10: An unsigned extended divide reports overflow one cycle after start unless the dividend source is unsigned-less-than the divisor source.
- R11: An operation without early overflow raises `done_o` exactly 2*XLEN+1 cycles after the start edge. `busy_o` stays high from the cycle after start until `done_o`, and the two are never high together.
- R12: A start pulse while `busy_o` is high is ignored, and the running operation finishes with its own result.
- R13: Reset clears `result_o`, `ovf_o`, `done_o` and `busy_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an operation when idle |
| op_i | input | 4 | Operation code: bit0 signed, bit1 word, bit2 remainder, bit3 extended |
| src_a_i | input | XLEN | Dividend source |
| src_b_i | input | XLEN | Divisor source |
| result_o | output | XLEN | Result, held until the next completion |
| ovf_o | output | 1 | Overflow flag of the last completed operation |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | Iteration in progress |

## Verification
The hardest case to reach is the signed extended divide whose quotient misses its destination width by exactly one. That overflow appears only at the end of the full iteration time, and never from an operand check. The stimulus reaches it with a dividend source of one and a divisor of two: the doubled dividend then gives a quotient of exactly the first non-representable power of two. Neighbouring divisors of four and minus four land just inside the range. Both the word and full-width variants are driven, together with a start pulse injected mid-iteration whose operands would have caused an immediate overflow had the pulse been accepted.

// File: rtl/divmod_pkg.sv
package divmod_pkg;

  typedef struct packed {
    logic ext;
    logic rem;
    logic word;
    logic sgn;
  } divmod_op_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } divmod_state_t;

endpackage

// File: rtl/divmod_prep.sv
module divmod_prep
  import divmod_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  divmod_op_t              op_i,
  input  logic [XLEN-1:0]         src_a_i,
  input  logic [XLEN-1:0]         src_b_i,
  output logic [2*XLEN-1:0]       dvd_mag_o,
  output logic [2*XLEN-1:0]       dvs_mag_o,
  output logic                    neg_q_o,
  output logic                    neg_r_o,
  output logic                    early_ovf_o
);

  localparam int N = 2 * XLEN;
  localparam int H = XLEN / 2;

  logic [H-1:0]    a_lo, b_lo;
  logic [XLEN-1:0] a_shw;
  logic [N-1:0]    dd, dv;
  logic            dd_min, dv_zero, dv_ones, a_below_b;
  logic            neg_dd, neg_dv;

  assign a_lo  = src_a_i[H-1:0];
  assign b_lo  = src_b_i[H-1:0];
  assign a_shw = {a_lo, {H{1'b0}}};

  // Operand formation at the doubled working width
  always_comb begin
    case ({op_i.ext, op_i.word})
      2'b00: begin
        dd = op_i.sgn ? {{XLEN{src_a_i[XLEN-1]}}, src_a_i} : {{XLEN{1'b0}}, src_a_i};
        dv = op_i.sgn ? {{XLEN{src_b_i[XLEN-1]}}, src_b_i} : {{XLEN{1'b0}}, src_b_i};
      end
      2'b01: begin
        dd = op_i.sgn ? {{(N-H){a_lo[H-1]}}, a_lo} : {{(N-H){1'b0}}, a_lo};
        dv = op_i.sgn ? {{(N-H){b_lo[H-1]}}, b_lo} : {{(N-H){1'b0}}, b_lo};
      end
      2'b10: begin
        dd = {src_a_i, {XLEN{1'b0}}};
        dv = op_i.sgn ? {{XLEN{src_b_i[XLEN-1]}}, src_b_i} : {{XLEN{1'b0}}, src_b_i};
      end
      default: begin
        dd = op_i.sgn ? {{XLEN{a_shw[XLEN-1]}}, a_shw} : {{XLEN{1'b0}}, a_shw};
        dv = op_i.sgn ? {{(N-H){b_lo[H-1]}}, b_lo} : {{(N-H){1'b0}}, b_lo};
      end
    endcase
  end

  // Overflow visible from the operands alone
  assign dd_min    = op_i.word ? (a_lo == {1'b1, {(H-1){1'b0}}})
                               : (src_a_i == {1'b1, {(XLEN-1){1'b0}}});
  assign dv_zero   = (dv == '0);
  assign dv_ones   = &dv;
  assign a_below_b = op_i.word ? (a_lo < b_lo) : (src_a_i < src_b_i);

  assign early_ovf_o = dv_zero
                     | (op_i.sgn & dv_ones & dd_min)
                     | (~op_i.sgn & op_i.ext & ~a_below_b);

  // Magnitudes and sign bookkeeping
  assign neg_dd    = op_i.sgn & dd[N-1];
  assign neg_dv    = op_i.sgn & dv[N-1];
  assign dvd_mag_o = neg_dd ? (~dd + 1'b1) : dd;
  assign dvs_mag_o = neg_dv ? (~dv + 1'b1) : dv;
  assign neg_q_o   = neg_dd ^ neg_dv;
  assign neg_r_o   = neg_dd;

endmodule

// File: rtl/divmod_core.sv
module divmod_core #(
  parameter int N = 128
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [N-1:0] dvd_i,
  input  logic [N-1:0] dvs_i,
  output logic [N-1:0] quo_o,
  output logic [N-1:0] rem_o,
  output logic         fin_o
);

  localparam int CW = $clog2(N + 1);

  logic [N:0]    part_q, part_d;
  logic [N-1:0]  quo_q, quo_d;
  logic [N-1:0]  dvs_q, dvs_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          run_q, run_d;
  logic          fin_q, fin_d;
  logic [N:0]    shifted, trial;
  logic          en;

  assign shifted = {part_q[N-1:0], quo_q[N-1]};
  assign trial   = shifted - {1'b0, dvs_q};

  // Next-state: one restoring step per cycle
  always_comb begin
    part_d = part_q;
    quo_d  = quo_q;
    dvs_d  = dvs_q;
    cnt_d  = cnt_q;
    run_d  = run_q;
    fin_d  = 1'b0;
    if (load_i) begin
      part_d = '0;
      quo_d  = dvd_i;
      dvs_d  = dvs_i;
      cnt_d  = CW'(N);
      run_d  = 1'b1;
    end else if (run_q) begin
      if (!trial[N]) begin
        part_d = trial;
        quo_d  = {quo_q[N-2:0], 1'b1};
      end else begin
        part_d = shifted;
        quo_d  = {quo_q[N-2:0], 1'b0};
      end
      cnt_d = cnt_q - 1'b1;
      run_d = (cnt_q != CW'(1));
      fin_d = (cnt_q == CW'(1));
    end
  end

  assign en = load_i | run_q | fin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      part_q <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      fin_q  <= 1'b0;
    end else if (en) begin
      part_q <= part_d;
      quo_q  <= quo_d;
      dvs_q  <= dvs_d;
      cnt_q  <= cnt_d;
      run_q  <= run_d;
      fin_q  <= fin_d;
    end
  end

  assign quo_o = quo_q;
  assign rem_o = part_q[N-1:0];
  assign fin_o = fin_q;

endmodule

// File: rtl/divmod_post.sv
module divmod_post
  import divmod_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  divmod_op_t        op_i,
  input  logic [2*XLEN-1:0] quo_mag_i,
  input  logic [2*XLEN-1:0] rem_mag_i,
  input  logic              neg_q_i,
  input  logic              neg_r_i,
  output logic [XLEN-1:0]   result_o,
  output logic              ovf_o
);

  localparam int N = 2 * XLEN;
  localparam int H = XLEN / 2;

  logic [N-1:0]    q, r;
  logic [XLEN-1:0] res;
  logic            fit_w, fit_x, fits;

  assign q = neg_q_i ? (~quo_mag_i + 1'b1) : quo_mag_i;
  assign r = neg_r_i ? (~rem_mag_i + 1'b1) : rem_mag_i;

  // Signed quotient must survive truncation to the destination width
  assign fit_w = (q[N-1:H-1] == '0) | (&q[N-1:H-1]);
  assign fit_x = (q[N-1:XLEN-1] == '0) | (&q[N-1:XLEN-1]);
  assign fits  = ~(op_i.ext & op_i.sgn) | (op_i.word ? fit_w : fit_x);

  always_comb begin
    if (op_i.ext) begin
      res = op_i.word ? {{H{1'b0}}, q[H-1:0]} : q[XLEN-1:0];
    end else if (op_i.rem) begin
      if (op_i.word)
        res = op_i.sgn ? {{H{r[H-1]}}, r[H-1:0]} : {{H{1'b0}}, r[H-1:0]};
      else
        res = r[XLEN-1:0];
    end else begin
      res = op_i.word ? {{H{1'b0}}, q[H-1:0]} : q[XLEN-1:0];
    end
  end

  assign result_o = fits ? res : '0;
  assign ovf_o    = ~fits;

endmodule

// File: rtl/divmod_unit.sv
module divmod_unit
  import divmod_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [3:0]      op_i,
  input  logic [XLEN-1:0] src_a_i,
  input  logic [XLEN-1:0] src_b_i,
  output logic [XLEN-1:0] result_o,
  output logic            ovf_o,
  output logic            done_o,
  output logic            busy_o
);

  localparam int N = 2 * XLEN;

  divmod_op_t      op_in, op_q;
  divmod_state_t   state_q, state_d;
  logic [N-1:0]    dvd_mag, dvs_mag, quo_mag, rem_mag;
  logic            neg_q, neg_r, early_ovf;
  logic            neg_q_q, neg_r_q;
  logic            core_load, core_fin;
  logic [XLEN-1:0] post_res, result_q, result_d;
  logic            post_ovf, ovf_q, ovf_d, done_q, done_d;

  assign op_in = divmod_op_t'(op_i);

  divmod_prep #(.XLEN(XLEN)) u_prep (
    .op_i        (op_in),
    .src_a_i     (src_a_i),
    .src_b_i     (src_b_i),
    .dvd_mag_o   (dvd_mag),
    .dvs_mag_o   (dvs_mag),
    .neg_q_o     (neg_q),
    .neg_r_o     (neg_r),
    .early_ovf_o (early_ovf)
  );

  divmod_core #(.N(N)) u_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (core_load),
    .dvd_i  (dvd_mag),
    .dvs_i  (dvs_mag),
    .quo_o  (quo_mag),
    .rem_o  (rem_mag),
    .fin_o  (core_fin)
  );

  divmod_post #(.XLEN(XLEN)) u_post (
    .op_i      (op_q),
    .quo_mag_i (quo_mag),
    .rem_mag_i (rem_mag),
    .neg_q_i   (neg_q_q),
    .neg_r_i   (neg_r_q),
    .result_o  (post_res),
    .ovf_o     (post_ovf)
  );

  assign core_load = (state_q == ST_IDLE) & start_i & ~early_ovf;

  // Next-state
  always_comb begin
    state_d  = state_q;
    result_d = result_q;
    ovf_d    = ovf_q;
    done_d   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          if (early_ovf) begin
            done_d   = 1'b1;
            ovf_d    = 1'b1;
            result_d = '0;
          end else begin
            state_d = ST_RUN;
          end
        end
      end
      default: begin
        if (core_fin) begin
          done_d   = 1'b1;
          ovf_d    = post_ovf;
          result_d = post_res;
          state_d  = ST_IDLE;
        end
      end
    endcase
  end

  // Registers with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      done_q   <= 1'b0;
      op_q     <= '0;
      neg_q_q  <= 1'b0;
      neg_r_q  <= 1'b0;
      result_q <= '0;
      ovf_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (core_load) begin
        op_q    <= op_in;
        neg_q_q <= neg_q;
        neg_r_q <= neg_r;
      end
      if (done_d) begin
        result_q <= result_d;
        ovf_q    <= ovf_d;
      end
    end
  end

  assign result_o = result_q;
  assign ovf_o    = ovf_q;
  assign done_o   = done_q;
  assign busy_o   = (state_q == ST_RUN);

endmodule

// File: rtl/divmod_unit_chk.sv
module divmod_unit_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start_i,
  input logic [3:0]      op_i,
  input logic [XLEN-1:0] src_a_i,
  input logic [XLEN-1:0] src_b_i,
  input logic [XLEN-1:0] result_o,
  input logic            ovf_o,
  input logic            done_o,
  input logic            busy_o
);

  localparam int H = XLEN / 2;

  logic b_is_zero, a_ge_b;
  assign b_is_zero = op_i[1] ? (src_b_i[H-1:0] == '0) : (src_b_i == '0);
  assign a_ge_b    = op_i[1] ? (src_a_i[H-1:0] >= src_b_i[H-1:0]) : (src_a_i >= src_b_i);

  p_sdiv_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && op_i[0] && b_is_zero) |=> (done_o && ovf_o));

  p_udiv_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && !op_i[0] && b_is_zero) |=> (done_o && ovf_o));

  p_ovf_zero_result_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |-> (result_o == '0));

  p_uext_order_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && op_i[3] && !op_i[0] && a_ge_b) |=> (done_o && ovf_o));

  p_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (busy_o || done_o));

  p_busy_done_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && done_o));

  p_busy_ignores_start_r12: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> (busy_o || done_o));

endmodule

bind divmod_unit divmod_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start_i  (start_i),
  .op_i     (op_i),
  .src_a_i  (src_a_i),
  .src_b_i  (src_b_i),
  .result_o (result_o),
  .ovf_o    (ovf_o),
  .done_o   (done_o),
  .busy_o   (busy_o)
);

// File: tb/divmod_unit_bench.sv
module divmod_unit_bench;

  localparam int XLEN = 64;
  localparam int N    = 2 * XLEN;
  localparam int H    = XLEN / 2;
  localparam logic [XLEN-1:0] MINX = {1'b1, {(XLEN-1){1'b0}}};
  localparam logic [H-1:0]    MINH = {1'b1, {(H-1){1'b0}}};

  logic            clk;
  logic            rst_n;
  logic            start_i;
  logic [3:0]      op_i;
  logic [XLEN-1:0] src_a_i, src_b_i;
  logic [XLEN-1:0] result_o;
  logic            ovf_o, done_o, busy_o;

  divmod_unit #(.XLEN(XLEN)) u_divmod_unit (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .op_i     (op_i),
    .src_a_i  (src_a_i),
    .src_b_i  (src_b_i),
    .result_o (result_o),
    .ovf_o    (ovf_o),
    .done_o   (done_o),
    .busy_o   (busy_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int    n_chk = 0;
  int    n_err = 0;
  string cur_req = "R13";
  bit    cmp_en = 1'b0;
  bit    finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Behavioural reference computation
  function automatic void ref_op(input logic [3:0] op, input logic [XLEN-1:0] a,
                                 input logic [XLEN-1:0] b, output logic early,
                                 output logic ovf, output logic [XLEN-1:0] res);
    logic sgn, word, rm, ext, bad, fits;
    logic [H-1:0] al, bl;
    logic [N-1:0] dd, dv, q, r;
    logic signed [N-1:0] sq, sr;
    sgn = op[0]; word = op[1]; rm = op[2]; ext = op[3];
    al = a[H-1:0]; bl = b[H-1:0];
    early = 1'b0; ovf = 1'b0; res = '0;
    if (word) begin
      dv = sgn ? {{(N-H){bl[H-1]}}, bl} : {{(N-H){1'b0}}, bl};
      if (ext) dd = {{(N-XLEN){sgn & al[H-1]}}, al, {H{1'b0}}};
      else     dd = sgn ? {{(N-H){al[H-1]}}, al} : {{(N-H){1'b0}}, al};
    end else begin
      dv = sgn ? {{XLEN{b[XLEN-1]}}, b} : {{XLEN{1'b0}}, b};
      if (ext) dd = {a, {XLEN{1'b0}}};
      else     dd = sgn ? {{XLEN{a[XLEN-1]}}, a} : {{XLEN{1'b0}}, a};
    end
    bad = 1'b0;
    if (dv == '0) bad = 1'b1;
    else if (sgn && dv == {N{1'b1}} && (word ? (al == MINH) : (a == MINX))) bad = 1'b1;
    else if (!sgn && ext) bad = word ? (al >= bl) : (a >= b);
    if (bad) begin
      early = 1'b1; ovf = 1'b1; res = '0;
      return;
    end
    if (sgn) begin
      sq = $signed(dd) / $signed(dv);
      sr = $signed(dd) % $signed(dv);
      q = sq; r = sr;
    end else begin
      q = dd / dv;
      r = dd % dv;
    end
    fits = 1'b1;
    if (ext && sgn)
      fits = word ? (q == {{(N-H){q[H-1]}}, q[H-1:0]})
                  : (q == {{(N-XLEN){q[XLEN-1]}}, q[XLEN-1:0]});
    if (!fits) begin
      ovf = 1'b1; res = '0;
      return;
    end
    if (ext || !rm) res = word ? {{H{1'b0}}, q[H-1:0]} : q[XLEN-1:0];
    else if (word)  res = sgn ? {{H{r[H-1]}}, r[H-1:0]} : {{H{1'b0}}, r[H-1:0]};
    else            res = r[XLEN-1:0];
  endfunction

  // Cycle model of the handshake
  bit              m_busy, m_done, m_ovf, p_ovf;
  int              m_cnt;
  logic [XLEN-1:0] m_res, p_res;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 1'b0; m_done = 1'b0; m_ovf = 1'b0; m_res = '0; m_cnt = 0;
    end else begin
      logic e, o;
      logic [XLEN-1:0] v;
      m_done = 1'b0;
      if (m_busy) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_busy = 1'b0; m_done = 1'b1; m_res = p_res; m_ovf = p_ovf;
        end
      end else if (start_i) begin
        ref_op(op_i, src_a_i, src_b_i, e, o, v);
        if (e) begin
          m_done = 1'b1; m_res = '0; m_ovf = 1'b1;
        end else begin
          m_busy = 1'b1; m_cnt = N + 1; p_res = v; p_ovf = o;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_en && rst_n) begin
      chk(busy_o == m_busy, "R11", "busy", XLEN'(busy_o), XLEN'(m_busy));
      chk(done_o == m_done, "R11", "done", XLEN'(done_o), XLEN'(m_done));
      if (m_done) begin
        chk(result_o == m_res, cur_req, "result", result_o, m_res);
        chk(ovf_o == m_ovf, cur_req, "overflow", XLEN'(ovf_o), XLEN'(m_ovf));
      end
    end
  end

  task automatic run_op(input string req, input logic [3:0] op,
                        input logic [XLEN-1:0] a, input logic [XLEN-1:0] b);
    @(negedge clk);
    cur_req = req;
    start_i = 1'b1; op_i = op; src_a_i = a; src_b_i = b;
    @(negedge clk);
    start_i = 1'b0;
    while (!m_done) @(negedge clk);
  endtask

  function automatic logic [XLEN-1:0] rnd_word();
    return XLEN'({$urandom(), $urandom()});
  endfunction

  initial begin
    #(20 * 150000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    start_i = 1'b0; op_i = '0; src_a_i = '0; src_b_i = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R13 reset state
    chk(result_o == '0, "R13", "reset result", result_o, '0);
    chk(ovf_o == 1'b0, "R13", "reset ovf", XLEN'(ovf_o), '0);
    chk(done_o == 1'b0, "R13", "reset done", XLEN'(done_o), '0);
    chk(busy_o == 1'b0, "R13", "reset busy", XLEN'(busy_o), '0);
    rst_n = 1'b1;
    cmp_en = 1'b1;

    run_op("R3", 4'h0, XLEN'(100), XLEN'(7));
    run_op("R3", 4'h0, '0 - XLEN'(1), XLEN'(0));
    run_op("R3", 4'h0, MINX, '1);
    run_op("R7", 4'h1, '0 - XLEN'(7), XLEN'(2));
    run_op("R7", 4'h5, '0 - XLEN'(7), XLEN'(2));
    run_op("R7", 4'h5, XLEN'(7), '0 - XLEN'(2));
    run_op("R7", 4'h1, XLEN'(7), '0 - XLEN'(2));
    run_op("R5", 4'h2, {{H{1'b1}}, 32'hFFFF_FFF0}, {{H{1'b1}}, 32'h0000_0010});
    run_op("R5", 4'h6, {{H{1'b1}}, 32'h0000_0067}, {{H{1'b0}}, 32'h0000_0010});
    run_op("R6", 4'h7, {{H{1'b0}}, 32'hFFFF_FFF9}, XLEN'(2));
    run_op("R6", 4'h3, {{H{1'b0}}, 32'hFFFF_FFF9}, XLEN'(2));
    run_op("R2", 4'h3, {{H{1'b0}}, MINH}, {{H{1'b0}}, {H{1'b1}}});
    run_op("R2", 4'h1, MINX, '1);
    run_op("R2", 4'h5, XLEN'(9), '0);
    run_op("R1", 4'h3, XLEN'(9), {{H{1'b1}}, {H{1'b0}}});
    run_op("R1", 4'h2, {{H{1'b1}}, 32'd50}, {32'd3, 32'd5});
    run_op("R8", 4'h8, XLEN'(1), XLEN'(3));
    run_op("R8", 4'hA, XLEN'(1), XLEN'(3));
    run_op("R8", 4'hC, XLEN'(1), XLEN'(3));
    run_op("R10", 4'h8, XLEN'(5), XLEN'(5));
    run_op("R10", 4'hA, XLEN'(5), XLEN'(3));
    run_op("R9", 4'h9, XLEN'(1), XLEN'(4));
    run_op("R9", 4'h9, XLEN'(1), XLEN'(2));
    run_op("R9", 4'h9, '1, XLEN'(2));
    run_op("R9", 4'hB, XLEN'(1), XLEN'(2));
    run_op("R9", 4'hB, XLEN'(1), '0 - XLEN'(4));
    run_op("R9", 4'hD, XLEN'(3), '0 - XLEN'(7));

    // R12: second start mid-iteration, with operands that would overflow at once
    @(negedge clk);
    cur_req = "R12";
    start_i = 1'b1; op_i = 4'h0; src_a_i = XLEN'(1000); src_b_i = XLEN'(9);
    @(negedge clk);
    start_i = 1'b0;
    repeat (10) @(negedge clk);
    start_i = 1'b1; op_i = 4'h1; src_a_i = XLEN'(5); src_b_i = '0;
    @(negedge clk);
    start_i = 1'b0;
    while (!m_done) @(negedge clk);

    for (int i = 0; i < 60; i++) begin
      logic [XLEN-1:0] a, b;
      a = rnd_word();
      b = rnd_word();
      if (i % 3 == 0) b = b >> ($urandom() % XLEN);
      run_op("R7", 4'($urandom()), a, b);
    end

    repeat (3) @(negedge clk);
    cmp_en = 1'b0;
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule